// File: doc/BRIEF.md
# Echo-Protector Preamble Sequencer

This block decides what a transmitter emits before its training sequence starts. When the echo-protector option is enabled, a start request first produces a stretch of unmodulated carrier. A gap with no transmitted energy follows, and then training begins. When the option is disabled, training begins at once. There is one exception: a selected long-train mode still inserts a silent stretch of the gap length before training. The block only sequences the phases. Carrier generation and the training signal itself belong to the datapath that reads `phase_o`.

The host drives the enable and the mode through `tone_en_i` and `long_mode_i`. These values are held in a configuration register and take effect only when `setup_i` is pulsed. All durations are counted in ticks of a slow time base `tick_i`. The tick period is a parameter, and the tick counts are derived from it. With the default 0.5 ms tick, the tone lasts 375 ticks and each 20 ms stretch lasts 40 ticks.

Top module: `epp_seq`

## Requirements
- R1: While reset is asserted and right after it, `phase_o` is idle (code 0), `train_start_o` is 0 and `protect_o` is 0. The latched enable resets to 1 and the latched long-train mode resets to 0.
- R2: If the latched enable is 1, a start request leads to tone (code 1) for exactly TONE_TICKS ticks, then gap (code 2) for exactly GAP_TICKS ticks, and then train (code 4).
- R3: If the latched enable is 0 and the latched long-train mode is 0, `phase_o` is train in the cycle after the clock edge that samples the start request. The tone, gap and silence phases do not occur.
- R4: If the latched enable is 0 and the latched long-train mode is 1, a start request leads to silence (code 3) for exactly GAP_TICKS ticks, and then train.
- R5: If the latched enable is 1 and the latched long-train mode is 1, the sequence is tone, then gap, then train, with no silence phase.
- R6: Changes on `tone_en_i` and `long_mode_i` have no effect until a clock edge at which `setup_i` is 1 latches them.
- R7: A start request is accepted only in idle. A request in any other phase does not restart or lengthen the sequence.
- R8: `train_start_o` is high for exactly one cycle, and that cycle is the first cycle of the train phase.
- R9: In train, `train_done_i` returns `phase_o` to idle at the next clock edge.
- R10: `protect_o` is 1 exactly while `phase_o` is tone or gap.
- R11: The timed phases advance only on tick cycles. With no ticks, the phase holds. Durations are the same in ticks whatever the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time-base tick |
| start_i | input | 1 | Request to begin the preamble |
| tone_en_i | input | 1 | Echo-protector enable from the host, before latching |
| long_mode_i | input | 1 | Long-train mode select from the host, before latching |
| setup_i | input | 1 | Strobe that latches enable and mode |
| train_done_i | input | 1 | Training has finished; return to idle |
| phase_o | output | 3 | Phase: 0 idle, 1 tone, 2 gap, 3 silence, 4 train |
| train_start_o | output | 1 | One-cycle pulse on entry to train |
| protect_o | output | 1 | High during tone and gap |

## Verification
The bench builds the block with TICK_US = 2500, so the tone takes 75 ticks and each gap or silence takes 8 ticks. Every ordering of enable and mode then runs to completion in a few hundred cycles. The tick spacing is varied across runs: a tick on every cycle, a tick every third cycle, and ticks switched off in the middle of a phase. This shows that phase lengths are counted in ticks and not in clock cycles. Because the short run lengths leave room for it, start requests are also injected mid-tone and mid-train.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_TONE  = 3'd1,
    PH_GAP   = 3'd2,
    PH_SIL   = 3'd3,
    PH_TRAIN = 3'd4
  } phase_e;
endpackage

// File: rtl/epp_cfg_latch.sv
module epp_cfg_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic setup_i,
  input  logic tone_en_i,
  input  logic long_mode_i,
  output logic en_o,
  output logic long_o
);
  logic en_q, long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b1;
      long_q <= 1'b0;
    end else if (setup_i) begin
      en_q   <= tone_en_i;
      long_q <= long_mode_i;
    end
  end

  assign en_o   = en_q;
  assign long_o = long_q;

  p_hold_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !setup_i |=> ($stable(en_q) && $stable(long_q)));
endmodule

// File: rtl/epp_tick_timer.sv
module epp_tick_timer #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && tick_i && (cnt_q == limit_i - 1'b1);

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/epp_seq.sv
module epp_seq
  import epp_pkg::*;
#(
  parameter int unsigned TICK_US = 500,
  parameter int unsigned TONE_US = 187500,
  parameter int unsigned GAP_US  = 20000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       tone_en_i,
  input  logic       long_mode_i,
  input  logic       setup_i,
  input  logic       train_done_i,
  output logic [2:0] phase_o,
  output logic       train_start_o,
  output logic       protect_o
);
  localparam int unsigned TONE_TICKS = TONE_US / TICK_US;
  localparam int unsigned GAP_TICKS  = GAP_US / TICK_US;
  localparam int unsigned MAX_TICKS  = (TONE_TICKS > GAP_TICKS) ? TONE_TICKS : GAP_TICKS;
  localparam int unsigned CNT_W      = $clog2(MAX_TICKS + 1);

  phase_e           phase_q, phase_d;
  logic             en_l, long_l, timer_done, timed;
  logic             train_start_q;
  logic [CNT_W-1:0] limit;

  epp_cfg_latch u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .setup_i    (setup_i),
    .tone_en_i  (tone_en_i),
    .long_mode_i(long_mode_i),
    .en_o       (en_l),
    .long_o     (long_l)
  );

  assign timed = (phase_q == PH_TONE) || (phase_q == PH_GAP) || (phase_q == PH_SIL);
  assign limit = (phase_q == PH_TONE) ? CNT_W'(TONE_TICKS) : CNT_W'(GAP_TICKS);

  epp_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(phase_d != phase_q),
    .run_i  (timed),
    .tick_i (tick_i),
    .limit_i(limit),
    .done_o (timer_done)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start_i) phase_d = en_l ? PH_TONE : (long_l ? PH_SIL : PH_TRAIN);
      PH_TONE:  if (timer_done) phase_d = PH_GAP;
      PH_GAP:   if (timer_done) phase_d = PH_TRAIN;
      PH_SIL:   if (timer_done) phase_d = PH_TRAIN;
      PH_TRAIN: if (train_done_i) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q       <= PH_IDLE;
      train_start_q <= 1'b0;
    end else begin
      phase_q       <= phase_d;
      train_start_q <= (phase_d == PH_TRAIN) && (phase_q != PH_TRAIN);
    end
  end

  assign phase_o       = phase_q;
  assign train_start_o = train_start_q;
  assign protect_o     = (phase_q == PH_TONE) || (phase_q == PH_GAP);

  p_tone_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TONE) |=> (phase_q inside {PH_TONE, PH_GAP}));
  p_gap_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_GAP) |=> (phase_q inside {PH_GAP, PH_TRAIN}));
  p_sil_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SIL) |=> (phase_q inside {PH_SIL, PH_TRAIN}));
  p_pulse_in_train_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_start_o |-> (phase_q == PH_TRAIN));
  p_pulse_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_start_o |=> !train_start_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TRAIN && train_done_i) |=> (phase_q == PH_IDLE));
  p_no_tick_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timed && !tick_i) |=> $stable(phase_q));
endmodule

// File: tb/tb_epp_seq.sv
module tb_epp_seq;
  localparam int TONE_T = 75;
  localparam int GAP_T  = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, start_i = 1'b0;
  logic tone_en_i = 1'b1, long_mode_i = 1'b0, setup_i = 1'b0, train_done_i = 1'b0;
  logic [2:0] phase_o;
  logic train_start_o, protect_o;

  int n_chk = 0, n_bad = 0;
  int tick_div = 1, tick_ph = 0;
  bit tick_on = 1'b1;
  int n_tone, n_gap, n_sil, n_ts, n_prot;
  bit done_flag = 1'b0;

  always #2.5 clk_i = ~clk_i;

  epp_seq #(.TICK_US(2500)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .tone_en_i(tone_en_i), .long_mode_i(long_mode_i), .setup_i(setup_i),
    .train_done_i(train_done_i), .phase_o(phase_o),
    .train_start_o(train_start_o), .protect_o(protect_o)
  );

  always @(posedge clk_i) begin
    tick_ph <= (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    tick_i  <= tick_on && (tick_ph == 0);
  end

  always @(negedge clk_i) begin
    if (tick_i && phase_o == 3'd1) n_tone++;
    if (tick_i && phase_o == 3'd2) n_gap++;
    if (tick_i && phase_o == 3'd3) n_sil++;
    if (train_start_o) n_ts++;
    if (rst_ni && protect_o != (phase_o == 3'd1 || phase_o == 3'd2)) n_prot++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_tone = 0; n_gap = 0; n_sil = 0; n_ts = 0;
  endtask

  task automatic cfg(input bit en, input bit lm);
    @(posedge clk_i); #1;
    tone_en_i = en; long_mode_i = lm; setup_i = 1'b1;
    @(posedge clk_i); #1;
    setup_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk_i); #1 start_i = 1'b1;
    @(posedge clk_i); #1 start_i = 1'b0;
  endtask

  task automatic wait_train();
    for (int i = 0; i < 5000 && phase_o != 3'd4; i++) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_train(input string req);
    @(posedge clk_i); #1 train_done_i = 1'b1;
    @(posedge clk_i); #1 train_done_i = 1'b0;
    @(negedge clk_i);
    check(phase_o == 3'd0, req, phase_o, 0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check(phase_o == 3'd0, "R1 phase", phase_o, 0);
    check(train_start_o == 1'b0, "R1 train_start", train_start_o, 0);
    check(protect_o == 1'b0, "R1 protect", protect_o, 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check(phase_o == 3'd0, "R1 idle after reset", phase_o, 0);
  endtask

  // latched enable defaults to 1: no setup issued before this run
  task automatic t_default_tone();
    clr_mon(); n_prot = 0;
    pulse_start(); wait_train();
    check(n_tone == TONE_T, "R1/R2 tone ticks", n_tone, TONE_T);
    check(n_gap == GAP_T, "R2 gap ticks", n_gap, GAP_T);
    check(n_sil == 0, "R2 no silence", n_sil, 0);
    check(n_ts == 1, "R8 pulse count", n_ts, 1);
    check(n_prot == 0, "R10 protect", n_prot, 0);
    finish_train("R9 back to idle");
  endtask

  task automatic t_direct();
    cfg(1'b0, 1'b0);
    clr_mon();
    @(posedge clk_i); #1 start_i = 1'b1;
    @(posedge clk_i); #1 start_i = 1'b0;
    @(negedge clk_i);
    check(phase_o == 3'd4, "R3 direct train", phase_o, 4);
    check(train_start_o == 1'b1, "R8 pulse first cycle", train_start_o, 1);
    @(negedge clk_i);
    check(train_start_o == 1'b0, "R8 pulse one cycle", train_start_o, 0);
    check(n_tone + n_gap + n_sil == 0, "R3 no preamble", n_tone + n_gap + n_sil, 0);
    finish_train("R9 idle");
  endtask

  task automatic t_long_silence();
    cfg(1'b0, 1'b1);
    clr_mon(); n_prot = 0;
    pulse_start(); wait_train();
    check(n_sil == GAP_T, "R4 silence ticks", n_sil, GAP_T);
    check(n_tone == 0, "R4 no tone", n_tone, 0);
    check(n_ts == 1, "R8 pulse count", n_ts, 1);
    check(n_prot == 0, "R10 protect low in silence", n_prot, 0);
    finish_train("R9 idle");
  endtask

  task automatic t_long_tone();
    cfg(1'b1, 1'b1);
    clr_mon();
    pulse_start(); wait_train();
    check(n_tone == TONE_T, "R5 tone ticks", n_tone, TONE_T);
    check(n_gap == GAP_T, "R5 gap ticks", n_gap, GAP_T);
    check(n_sil == 0, "R5 no silence", n_sil, 0);
    finish_train("R9 idle");
  endtask

  task automatic t_no_setup();
    cfg(1'b1, 1'b0);
    @(posedge clk_i); #1 tone_en_i = 1'b0; long_mode_i = 1'b1;
    clr_mon();
    pulse_start(); wait_train();
    check(n_tone == TONE_T, "R6 enable not latched", n_tone, TONE_T);
    check(n_sil == 0, "R6 mode not latched", n_sil, 0);
    finish_train("R9 idle");
    cfg(1'b0, 1'b0);
    clr_mon();
    pulse_start(); @(negedge clk_i);
    check(phase_o == 3'd4, "R6 latched by setup", phase_o, 4);
    finish_train("R9 idle");
  endtask

  task automatic t_start_ignored();
    cfg(1'b1, 1'b0);
    clr_mon();
    pulse_start();
    for (int i = 0; i < 20; i++) @(negedge clk_i);
    pulse_start();
    wait_train();
    check(n_tone == TONE_T, "R7 restart in tone", n_tone, TONE_T);
    pulse_start();
    @(negedge clk_i);
    check(phase_o == 3'd4, "R7 start in train", phase_o, 4);
    check(n_ts == 1, "R7 no second pulse", n_ts, 1);
    finish_train("R9 idle");
  endtask

  task automatic t_tick_spacing();
    cfg(1'b1, 1'b0);
    tick_div = 3;
    clr_mon(); n_prot = 0;
    pulse_start();
    for (int i = 0; i < 30; i++) @(negedge clk_i);
    tick_on = 1'b0;
    for (int i = 0; i < 40; i++) @(negedge clk_i);
    check(phase_o == 3'd1, "R11 hold without ticks", phase_o, 1);
    tick_on = 1'b1;
    wait_train();
    check(n_tone == TONE_T, "R11 tone ticks div3", n_tone, TONE_T);
    check(n_gap == GAP_T, "R11 gap ticks div3", n_gap, GAP_T);
    check(n_prot == 0, "R10 protect div3", n_prot, 0);
    finish_train("R9 idle");
    tick_div = 1;
  endtask

  initial begin
    for (int i = 0; i < 100000 && !done_flag; i++) @(posedge clk_i);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_prot = 0;
    clr_mon();
    t_reset();
    t_default_tone();
    t_direct();
    t_long_silence();
    t_long_tone();
    t_no_setup();
    t_start_ignored();
    t_tick_spacing();
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule